// File: doc/BRIEF.md
# Microprogram Sequencer with Single-Level Subroutine

This block is the core of a microprogrammed control unit. A control address register points into a small read-only control store whose contents come from a parameter. Every stored word has two parts. The control part goes straight to the datapath as the set of controls for one clock. The sequencing part tells the block where the next word is fetched from.

Six sequencing operations are available:
- step to the following word;
- jump to an address held in the word;
- branch on one status bit picked by a field of the word;
- dispatch on a machine opcode;
- call a routine, with the return address kept in one register;
- return from that routine.

The whole cycle uses one clock edge per microinstruction: the next address is formed, the store is read and the control word is applied.

The reset input is asserted asynchronously and released synchronously inside the block. All state starts at address 0, where the fetch routine lives.

Top module: `useq_core`

## Requirements
- R1: While reset is low, `uaddr` is 0 and `ctrl_word` is the control field of word 0. After `rst_n` rises, the address stays 0 for two more rising edges and first advances on the third.
- R2: Each stored word is laid out as {control[CW_W-1:0], status select[SEL_W-1:0], sequencing code[2:0], target address[ADDR_W-1:0]}, with the target address in the least significant bits. Word a occupies bits [a*WORD_W +: WORD_W] of `ROM_INIT`. `ctrl_word` always equals the control field of the word at the current `uaddr`.
- R3: Code 000 (step) loads `uaddr`+1. The increment wraps from the last address to 0.
- R4: Code 001 (jump) loads the target address field.
- R5: Code 010 (test) loads the target address when `status[select]` is 1, and `uaddr`+1 otherwise. No other status bit has any effect.
- R6: Code 011 (dispatch) loads the address {1'b1, opcode, 2'b00}, which gives every opcode a four-word area.
- R7: Code 100 (call) loads the target address and stores `uaddr`+1 in the return register.
- R8: Code 101 (return) loads the return register. The return register is 0 after reset, so a return with no earlier call goes to address 0. The return register keeps its value across returns.
- R9: The unused codes 110 and 111 behave as a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one microinstruction per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opcode | input | OP_W | Machine opcode used by the dispatch operation |
| status | input | STAT_N | Datapath status bits for the test operation |
| ctrl_word | output | CW_W | Control field of the current microinstruction |
| uaddr | output | OP_W+3 | Current control address |

## Verification
The bench builds the block with OP_W=4, CW_W=8 and STAT_N=4. This gives a 128-word store, a 2-bit status select and dispatch targets across the full upper half, from 64 for opcode 0 to 124 for opcode 15.

With these values, one loaded program covers all of the following:
- the wrap from address 127 back to 0;
- a test whose selected bit is 0 while every other status bit is 1;
- a return made before any call;
- a call whose saved address is later reused by a second return.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  typedef enum logic [2:0] {
    SQ_NEXT = 3'b000,
    SQ_JUMP = 3'b001,
    SQ_TEST = 3'b010,
    SQ_DISP = 3'b011,
    SQ_CALL = 3'b100,
    SQ_RET  = 3'b101
  } seq_op_e;

  localparam int SEQ_OP_W = 3;
endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/useq_store.sv
module useq_store #(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 20,
  parameter int DEPTH  = 128,
  parameter logic [DEPTH*WORD_W-1:0] ROM_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] word_d;

  always_comb begin
    word_d = ROM_INIT[rd_addr*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_word <= ROM_INIT[WORD_W-1:0];
    else        rd_word <= word_d;
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import ucode_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int ADDR_W = 7,
  parameter int STAT_N = 4,
  parameter int SEL_W  = 2
) (
  input  logic [ADDR_W-1:0]   car,
  input  logic [ADDR_W-1:0]   sbr,
  input  logic [2:0]          op,
  input  logic [SEL_W-1:0]    sel,
  input  logic [ADDR_W-1:0]   target,
  input  logic [OP_W-1:0]     opcode,
  input  logic [STAT_N-1:0]   status,
  output logic [ADDR_W-1:0]   car_nxt,
  output logic [ADDR_W-1:0]   sbr_nxt,
  output logic                sbr_ld
);
  logic [ADDR_W-1:0] inc;

  always_comb begin
    inc     = car + 1'b1;
    car_nxt = inc;
    sbr_nxt = inc;
    sbr_ld  = 1'b0;
    case (op)
      SQ_NEXT: car_nxt = inc;
      SQ_JUMP: car_nxt = target;
      SQ_TEST: if (status[sel]) car_nxt = target;
      SQ_DISP: car_nxt = {1'b1, opcode, 2'b00};
      SQ_CALL: begin
        car_nxt = target;
        sbr_ld  = 1'b1;
      end
      SQ_RET:  car_nxt = sbr;
      default: car_nxt = inc;
    endcase
  end
endmodule

// File: rtl/useq_core.sv
module useq_core
  import ucode_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int CW_W   = 8,
  parameter int STAT_N = 4,
  parameter int ADDR_W = OP_W + 3,
  parameter int SEL_W  = (STAT_N > 1) ? $clog2(STAT_N) : 1,
  parameter int WORD_W = CW_W + SEL_W + SEQ_OP_W + ADDR_W,
  parameter int DEPTH  = 1 << ADDR_W,
  parameter logic [DEPTH*WORD_W-1:0] ROM_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   opcode,
  input  logic [STAT_N-1:0] status,
  output logic [CW_W-1:0]   ctrl_word,
  output logic [OP_W+2:0]   uaddr
);
  logic              srst_n;
  logic [ADDR_W-1:0] car_q, car_d, sbr_q, sbr_d, car_nxt, sbr_nxt;
  logic              sbr_ld;
  logic [WORD_W-1:0] uw_q;
  logic [2:0]        uw_op;
  logic [SEL_W-1:0]  uw_sel;
  logic [ADDR_W-1:0] uw_tgt;

  useq_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  assign uw_tgt    = uw_q[ADDR_W-1:0];
  assign uw_op     = uw_q[ADDR_W +: SEQ_OP_W];
  assign uw_sel    = uw_q[ADDR_W+SEQ_OP_W +: SEL_W];
  assign ctrl_word = uw_q[WORD_W-1 -: CW_W];
  assign uaddr     = car_q;

  useq_next_addr #(.OP_W(OP_W), .ADDR_W(ADDR_W), .STAT_N(STAT_N), .SEL_W(SEL_W)) u_next (
    .car(car_q), .sbr(sbr_q), .op(uw_op), .sel(uw_sel), .target(uw_tgt),
    .opcode(opcode), .status(status),
    .car_nxt(car_nxt), .sbr_nxt(sbr_nxt), .sbr_ld(sbr_ld)
  );

  useq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DEPTH(DEPTH), .ROM_INIT(ROM_INIT)) u_store (
    .clk(clk), .rst_n(srst_n), .rd_addr(car_nxt), .rd_word(uw_q)
  );

  always_comb begin
    car_d = car_nxt;
    sbr_d = sbr_ld ? sbr_nxt : sbr_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      car_q <= '0;
      sbr_q <= '0;
    end else begin
      car_q <= car_d;
      if (sbr_ld) sbr_q <= sbr_d;
    end
  end

  assert_ctrl_R2: assert property (@(posedge clk) disable iff (!srst_n)
    uw_q == ROM_INIT[car_q*WORD_W +: WORD_W]);
  assert_step_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (uw_op == SQ_NEXT) |=> (car_q == ADDR_W'($past(car_q) + 1'b1)));
  assert_jump_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (uw_op == SQ_JUMP) |=> (car_q == $past(uw_tgt)));
  assert_taken_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (uw_op == SQ_TEST && status[uw_sel]) |=> (car_q == $past(uw_tgt)));
  assert_fall_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (uw_op == SQ_TEST && !status[uw_sel]) |=> (car_q == ADDR_W'($past(car_q) + 1'b1)));
  assert_disp_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (uw_op == SQ_DISP) |=> (car_q == {1'b1, $past(opcode), 2'b00}));
  assert_call_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (uw_op == SQ_CALL) |=> (sbr_q == ADDR_W'($past(car_q) + 1'b1) && car_q == $past(uw_tgt)));
  assert_ret_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (uw_op == SQ_RET) |=> (car_q == $past(sbr_q) && $stable(sbr_q)));
  assert_spare_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (uw_op[2:1] == 2'b11) |=> (car_q == ADDR_W'($past(car_q) + 1'b1)));
endmodule

// File: tb/tb_useq_core.sv
`timescale 1ns/1ps
module tb_useq_core;
  localparam int OP_W = 4, CW_W = 8, STAT_N = 4;
  localparam int ADDR_W = OP_W + 3, SEL_W = 2;
  localparam int WORD_W = CW_W + SEL_W + 3 + ADDR_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int ROM_BITS = DEPTH * WORD_W;

  function automatic logic [CW_W-1:0] ctrl_of(input int a);
    return CW_W'(a * 7 + 3);
  endfunction

  function automatic logic [WORD_W-1:0] mk(input int a, input logic [1:0] sel,
                                           input logic [2:0] op, input logic [ADDR_W-1:0] tgt);
    return {ctrl_of(a), sel, op, tgt};
  endfunction

  function automatic logic [ROM_BITS-1:0] build_prog();
    logic [ROM_BITS-1:0] p;
    p = '0;
    for (int a = 0; a < DEPTH; a++) begin
      case (a)
        2:       p[a*WORD_W +: WORD_W] = mk(a, 2'd0, 3'b011, 7'd0);
        84:      p[a*WORD_W +: WORD_W] = mk(a, 2'd2, 3'b010, 7'd90);
        85:      p[a*WORD_W +: WORD_W] = mk(a, 2'd0, 3'b100, 7'd100);
        86:      p[a*WORD_W +: WORD_W] = mk(a, 2'd0, 3'b001, 7'd0);
        90:      p[a*WORD_W +: WORD_W] = mk(a, 2'd0, 3'b101, 7'd0);
        101:     p[a*WORD_W +: WORD_W] = mk(a, 2'd0, 3'b101, 7'd0);
        64:      p[a*WORD_W +: WORD_W] = mk(a, 2'd3, 3'b110, 7'd33);
        65:      p[a*WORD_W +: WORD_W] = mk(a, 2'd1, 3'b111, 7'd44);
        66:      p[a*WORD_W +: WORD_W] = mk(a, 2'd0, 3'b101, 7'd0);
        default: p[a*WORD_W +: WORD_W] = mk(a, 2'd0, 3'b000, 7'd55);
      endcase
    end
    return p;
  endfunction

  localparam logic [ROM_BITS-1:0] PROG = build_prog();

  logic clk = 1'b0;
  logic rst_n;
  logic [OP_W-1:0] opcode;
  logic [STAT_N-1:0] status;
  logic [CW_W-1:0] ctrl_word;
  logic [ADDR_W-1:0] uaddr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [ADDR_W-1:0] exp_q[$];
  string req_q[$];

  always #2 clk = ~clk;

  useq_core #(.OP_W(OP_W), .CW_W(CW_W), .STAT_N(STAT_N), .ROM_INIT(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .status(status),
    .ctrl_word(ctrl_word), .uaddr(uaddr)
  );

  task automatic chk(input string r, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, got, exp);
    end
  endtask

  task automatic push(input logic [ADDR_W-1:0] a, input string r);
    exp_q.push_back(a);
    req_q.push_back(r);
    @(negedge clk);
  endtask

  // monitor: pops one expected address per clock, after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [ADDR_W-1:0] a;
        string r;
        a = exp_q.pop_front();
        r = req_q.pop_front();
        chk(r, "address", int'(uaddr), int'(a));
        chk({r, "/R2"}, "control word", int'(ctrl_word), int'(ctrl_of(int'(a))));
      end
    end
  end

  // driver
  initial begin
    rst_n = 1'b0;
    opcode = 4'd0;
    status = 4'b0000;
    repeat (3) @(negedge clk);
    chk("R1", "address in reset", int'(uaddr), 0);
    chk("R1", "control in reset", int'(ctrl_word), int'(ctrl_of(0)));
    rst_n = 1'b1;
    push(7'd0, "R1");
    push(7'd0, "R1");
    // pass 1: dispatch opcode 0, spare codes, return with no prior call
    push(7'd1, "R3");
    push(7'd2, "R3");
    push(7'd64, "R6");
    push(7'd65, "R9");
    push(7'd66, "R9");
    push(7'd0, "R8");
    // pass 2: opcode 5, selected bit 2 clear while others set
    opcode = 4'd5;
    status = 4'b1011;
    push(7'd1, "R3");
    push(7'd2, "R3");
    push(7'd84, "R6");
    push(7'd85, "R5");
    push(7'd100, "R7");
    push(7'd101, "R3");
    push(7'd86, "R8");
    push(7'd0, "R4");
    // pass 3: selected bit 2 set; return reuses the saved address
    status = 4'b0100;
    push(7'd1, "R3");
    push(7'd2, "R3");
    push(7'd84, "R6");
    push(7'd90, "R5");
    push(7'd86, "R8");
    push(7'd0, "R4");
    // pass 4: opcode 15, run to the top and wrap
    opcode = 4'd15;
    status = 4'b0000;
    push(7'd1, "R3");
    push(7'd2, "R3");
    push(7'd124, "R6");
    push(7'd125, "R3");
    push(7'd126, "R3");
    push(7'd127, "R3");
    push(7'd0, "R3");
    push(7'd1, "R3");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule